// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block is the master for a three-wire serial EEPROM that stores 16-bit words. A host asks for one operation at a time with a one-cycle `start` strobe, a 2-bit operation code, a 6-bit word address and, for writes, a 16-bit data word. The block then drives chip select, serial clock and serial data-out itself, and samples the device's serial data-in. It reports the result with `busy`, a one-cycle `done` pulse, the word read back and an error flag.

A write runs as one self-contained transaction made of four selections of the device. The first enables writing. The second carries the write frame and the data word. The third holds the device selected and polls data-in until the device reports ready. The fourth disables writing again. Polling happens at a fixed interval and gives up after a bounded number of checks. Every pin movement takes place on a half-period tick from a programmable divider (`HALF_CYC` clocks).

State machine (`state_t`):
- `S_IDLE`: waits for a start.
- `S_SEL`: three half-periods: all pins low, then CS high, then SCK high.
- `S_CMD`: shifts out the 11-bit frame.
- `S_WDAT`: shifts out the write word.
- `S_RDAT`: shifts in the read word.
- `S_POLL`: checks data-in every `POLL_CYC` clocks.
- `S_DESEL`: three half-periods: SCK and data-out low, then CS low, then SCK high.
- `S_DONE`: lasts one cycle.

Transitions:
- `S_IDLE`→`S_SEL` on a start.
- `S_SEL`→`S_POLL` in the poll selection, and `S_SEL`→`S_CMD` otherwise.
- `S_CMD`→`S_WDAT` in the write selection, `S_CMD`→`S_RDAT` for a read, and `S_CMD`→`S_DESEL` otherwise.
- `S_WDAT`/`S_RDAT`→`S_DESEL` after 16 bits.
- `S_POLL`→`S_DESEL` on ready or when the checks run out.
- `S_DESEL`→`S_SEL` while the write sequence (enable → write → poll → disable) has a selection left, and `S_DESEL`→`S_DONE` otherwise.
- `S_DONE`→`S_IDLE`.

Top module: `mwe_ctrl`

## Requirements
- R1: After reset, `ee_cs`=0, `ee_sck`=1, `ee_do`=0, `busy`=0, `done`=0 and `err`=0.
- R2: Each command frame is 11 bits sent MSB first. It is a 5-bit code followed by the 6-bit address. The codes are read 10110, write 10101, write-enable 10011 and write-disable 10000. `op` encodes read=0, write=1, write-enable=2 and write-disable=3.
- R3: Each bit cell holds SCK low for `HALF_CYC` clocks and then high for `HALF_CYC` clocks. `ee_do` changes only while SCK is low.
- R4: When CS rises, SCK and data-out are already low, and SCK then pulses high. When CS falls, SCK is low.
- R5: Data-out is low whenever CS falls, both after the command bits and after the write data bits.
- R6: A read shifts in 16 bits MSB first. Each bit is taken at the end of the SCK high half, and the word is valid on `rdata` while `done` is high.
- R7: A write performs four selections in order: write-enable, write (frame plus 16 data bits MSB first), ready poll, write-disable.
- R8: During the poll, data-in is checked every `POLL_CYC` clocks, starting one interval after the select completes. The first high check ends the poll and leaves `err`=0.
- R9: If data-in is still low after `POLL_MAX` checks, `err` is set. The write-disable selection and `done` still follow. `err` clears on the next accepted start.
- R10: A `start` while `busy` is high is ignored.
- R11: `done` is high for exactly one cycle at the end of each operation, with `busy` still high. `busy` is low in the next cycle.
- R12: A stand-alone write-enable or write-disable sends only its frame, with all address bits zero and no data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only when idle |
| op | input | 2 | Operation code |
| addr | input | 6 | Word address |
| wdata | input | 16 | Word to write |
| rdata | output | 16 | Word read from the device |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready poll timed out |
| ee_cs | output | 1 | Device chip select |
| ee_sck | output | 1 | Serial clock |
| ee_do | output | 1 | Serial data to the device |
| ee_di | input | 1 | Serial data from the device |

## Verification
The bench builds the block with `HALF_CYC`=2, `POLL_CYC`=20 and `POLL_MAX`=6. With these values a timed-out poll lasts only 126 cycles, so the bench can run the full timeout path and recovery alongside a successful poll. That successful poll ends on its third check. The short half-period puts exact bit-cell lengths and exact CS-high durations within reach. These are compared against counts derived from the divider and poll parameters.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

    localparam int FRAME_W = 11;
    localparam int ADDR_W  = 6;
    localparam int CODE_W  = FRAME_W - ADDR_W;
    localparam int WORD_W  = 16;
    localparam int BIT_W   = $clog2(WORD_W > FRAME_W ? WORD_W : FRAME_W);

    localparam logic [CODE_W-1:0] CODE_READ  = 5'b10110;
    localparam logic [CODE_W-1:0] CODE_WRITE = 5'b10101;
    localparam logic [CODE_W-1:0] CODE_WEN   = 5'b10011;
    localparam logic [CODE_W-1:0] CODE_WDS   = 5'b10000;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WEN   = 2'd2,
        OP_WDS   = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        S_IDLE, S_SEL, S_CMD, S_WDAT, S_RDAT, S_DESEL, S_POLL, S_DONE
    } state_t;

    typedef enum logic [2:0] {
        PH_ONE, PH_WEN, PH_WR, PH_POLL, PH_WDS
    } phase_t;

endpackage

// File: rtl/mwe_tick.sv
module mwe_tick #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/mwe_frame.sv
module mwe_frame
    import mwe_pkg::*;
(
    input  phase_t              phase,
    input  op_t                 op,
    input  logic [ADDR_W-1:0]   addr,
    output logic [FRAME_W-1:0]  frame
);

    localparam logic [ADDR_W-1:0] NO_ADDR = {ADDR_W{1'b0}};

    always_comb begin
        unique case (phase)
            PH_WEN:  frame = {CODE_WEN, NO_ADDR};
            PH_WDS:  frame = {CODE_WDS, NO_ADDR};
            PH_WR:   frame = {CODE_WRITE, addr};
            default: begin
                unique case (op)
                    OP_READ:  frame = {CODE_READ, addr};
                    OP_WRITE: frame = {CODE_WRITE, addr};
                    OP_WEN:   frame = {CODE_WEN, NO_ADDR};
                    default:  frame = {CODE_WDS, NO_ADDR};
                endcase
            end
        endcase
    end

endmodule

// File: rtl/mwe_ctrl.sv
module mwe_ctrl
    import mwe_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int POLL_CYC = 12500,
    parameter int POLL_MAX = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              ee_cs,
    output logic              ee_sck,
    output logic              ee_do,
    input  logic              ee_di
);

    localparam int PCW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
    localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_MAX - 1);

    state_t              state, n_state;
    phase_t              phase, n_phase;
    logic [1:0]          step, n_step;
    logic [BIT_W-1:0]    bitn, n_bit;
    logic [PCW-1:0]      polls, n_polls;
    op_t                 op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [WORD_W-1:0]   wdata_q;
    logic [WORD_W-1:0]   rsh;
    logic [FRAME_W-1:0]  frame;
    logic                htick, ptick, adv, timeout;

    mwe_tick #(.LIMIT(HALF_CYC)) u_half (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state inside {S_SEL, S_CMD, S_WDAT, S_RDAT, S_DESEL}),
        .tick (htick)
    );

    mwe_tick #(.LIMIT(POLL_CYC)) u_poll (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == S_POLL),
        .tick (ptick)
    );

    mwe_frame u_frame (
        .phase(phase),
        .op   (op_q),
        .addr (addr_q),
        .frame(frame)
    );

    assign busy    = (state != S_IDLE);
    assign done    = (state == S_DONE);
    assign rdata   = rsh;
    assign timeout = (state == S_POLL) && ptick && !ee_di && (polls == POLL_LAST);

    // next-state logic
    always_comb begin
        n_state = state;
        n_phase = phase;
        n_step  = step;
        n_bit   = bitn;
        n_polls = polls;
        adv     = 1'b0;
        unique case (state)
            S_IDLE: if (start) begin
                adv     = 1'b1;
                n_state = S_SEL;
                n_step  = 2'd0;
                n_phase = (op_t'(op) == OP_WRITE) ? PH_WEN : PH_ONE;
            end
            S_SEL: if (htick) begin
                adv = 1'b1;
                if (step == 2'd2) begin
                    n_step = 2'd0;
                    if (phase == PH_POLL) begin
                        n_state = S_POLL;
                        n_polls = '0;
                    end else begin
                        n_state = S_CMD;
                        n_bit   = BIT_W'(FRAME_W - 1);
                    end
                end else
                    n_step = step + 2'd1;
            end
            S_CMD, S_WDAT, S_RDAT: if (htick) begin
                adv = 1'b1;
                if (step == 2'd0)
                    n_step = 2'd1;
                else begin
                    n_step = 2'd0;
                    if (bitn != '0)
                        n_bit = bitn - 1'b1;
                    else if (state == S_CMD && phase == PH_WR) begin
                        n_state = S_WDAT;
                        n_bit   = BIT_W'(WORD_W - 1);
                    end else if (state == S_CMD && phase == PH_ONE && op_q == OP_READ) begin
                        n_state = S_RDAT;
                        n_bit   = BIT_W'(WORD_W - 1);
                    end else
                        n_state = S_DESEL;
                end
            end
            S_POLL: if (ptick) begin
                if (ee_di || polls == POLL_LAST) begin
                    adv     = 1'b1;
                    n_state = S_DESEL;
                    n_step  = 2'd0;
                end else
                    n_polls = polls + 1'b1;
            end
            S_DESEL: if (htick) begin
                adv = 1'b1;
                if (step == 2'd2) begin
                    n_step = 2'd0;
                    unique case (phase)
                        PH_WEN:  begin n_phase = PH_WR;   n_state = S_SEL; end
                        PH_WR:   begin n_phase = PH_POLL; n_state = S_SEL; end
                        PH_POLL: begin n_phase = PH_WDS;  n_state = S_SEL; end
                        default: n_state = S_DONE;
                    endcase
                end else
                    n_step = step + 2'd1;
            end
            S_DONE:  n_state = S_IDLE;
            default: n_state = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            phase   <= PH_ONE;
            step    <= 2'd0;
            bitn    <= '0;
            polls   <= '0;
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            err     <= 1'b0;
        end else begin
            state <= n_state;
            phase <= n_phase;
            step  <= n_step;
            bitn  <= n_bit;
            polls <= n_polls;
            if (state == S_IDLE && start) begin
                op_q    <= op_t'(op);
                addr_q  <= addr;
                wdata_q <= wdata;
                err     <= 1'b0;
            end else if (timeout)
                err <= 1'b1;
        end
    end

    // pin and capture register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ee_cs  <= 1'b0;
            ee_sck <= 1'b1;
            ee_do  <= 1'b0;
            rsh    <= '0;
        end else if (adv) begin
            if (state == S_RDAT && step == 2'd1)
                rsh <= {rsh[WORD_W-2:0], ee_di};
            unique case (n_state)
                S_SEL: begin
                    unique case (n_step)
                        2'd0: begin ee_cs <= 1'b0; ee_sck <= 1'b0; ee_do <= 1'b0; end
                        2'd1: ee_cs <= 1'b1;
                        default: ee_sck <= 1'b1;
                    endcase
                end
                S_CMD: begin
                    if (n_step == 2'd0) begin ee_sck <= 1'b0; ee_do <= frame[n_bit]; end
                    else ee_sck <= 1'b1;
                end
                S_WDAT: begin
                    if (n_step == 2'd0) begin ee_sck <= 1'b0; ee_do <= wdata_q[n_bit]; end
                    else ee_sck <= 1'b1;
                end
                S_RDAT: ee_sck <= (n_step != 2'd0);
                S_DESEL: begin
                    unique case (n_step)
                        2'd0: begin ee_sck <= 1'b0; ee_do <= 1'b0; end
                        2'd1: ee_cs <= 1'b0;
                        default: ee_sck <= 1'b1;
                    endcase
                end
                default: ;
            endcase
        end
    end

    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (!ee_sck && !ee_do)) else $error("select with sck/do high"); // R4
    AST_DESEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> (!ee_sck && !ee_do)) else $error("deselect with sck/do high"); // R5
    AST_DO_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_do) |-> !ee_sck) else $error("data moved while sck high"); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R11
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy) else $error("done without busy"); // R11
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ee_cs) else $error("cs high while idle"); // R1
    AST_ERR_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(state) == S_POLL)) else $error("err set outside poll"); // R9

endmodule

// File: tb/test_mwe_ctrl.sv
module test_mwe_ctrl;
    import mwe_pkg::*;

    localparam int H = 2;
    localparam int P = 20;
    localparam int M = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [5:0]  addr = 6'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        busy, done, err, ee_cs, ee_sck, ee_do;
    logic        ee_di = 1'b0;

    mwe_ctrl #(.HALF_CYC(H), .POLL_CYC(P), .POLL_MAX(M)) i_mwe_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .done(done), .err(err),
        .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_do(ee_do), .ee_di(ee_di)
    );

    always #4ns clk = ~clk;

    int total = 0;
    int bad = 0;

    // ---------------- device model ----------------
    logic [15:0] mem [0:63];
    int          prog_delay = 60;
    int          prog_cnt = 0;
    logic        cs_p = 1'b0, sck_p = 1'b1, started = 1'b0;
    int          nbits = 0, wcnt = 0;
    logic [10:0] fr = '0;
    logic        rd_act = 1'b0, wr_act = 1'b0, rd_bit = 1'b0, wen = 1'b0;
    logic [15:0] wbuf = '0, rd_word = '0;
    logic [5:0]  waddr = '0;
    int          nsel = 0, nlog = 0, cur_len = 0, cyc = 0, last_rise = -1, period = 0;
    int          viol_sel = 0, viol_desel = 0;
    int          log_code [64];
    int          log_addr [64];
    int          sel_len  [64];

    always @(negedge clk) begin
        cyc++;
        if (prog_cnt > 0) prog_cnt--;
        if (ee_cs && !cs_p) begin
            nsel++; cur_len = 0; started = 1'b0; nbits = 0;
            rd_act = 1'b0; wr_act = 1'b0; wcnt = 0; last_rise = -1;
            if (ee_sck || ee_do) viol_sel++;
        end
        if (!ee_cs && cs_p) begin
            sel_len[(nsel - 1) & 63] = cur_len;
            if (ee_sck) viol_sel++;
            if (ee_do) viol_desel++;
            if (wr_act && wcnt == 16 && wen) begin
                mem[waddr] = wbuf;
                prog_cnt = prog_delay;
            end
            wr_act = 1'b0; rd_act = 1'b0;
        end
        if (ee_cs) cur_len++;
        if (ee_cs && ee_sck && !sck_p) begin
            if (last_rise >= 0) period = cyc - last_rise;
            last_rise = cyc;
            if (rd_act) begin
                rd_bit = rd_word[15];
                rd_word = {rd_word[14:0], 1'b0};
            end else if (wr_act) begin
                if (wcnt < 16) begin wbuf = {wbuf[14:0], ee_do}; wcnt++; end
            end else if (!started) begin
                if (ee_do) begin started = 1'b1; fr = 11'd1; nbits = 1; end
            end else if (nbits < 11) begin
                fr = {fr[9:0], ee_do};
                nbits++;
                if (nbits == 11) begin
                    log_code[nlog & 63] = int'(fr[10:6]);
                    log_addr[nlog & 63] = int'(fr[5:0]);
                    nlog++;
                    case (fr[10:6])
                        CODE_READ:  begin rd_act = 1'b1; rd_word = mem[fr[5:0]]; end
                        CODE_WRITE: begin wr_act = 1'b1; waddr = fr[5:0]; end
                        CODE_WEN:   wen = 1'b1;
                        CODE_WDS:   wen = 1'b0;
                        default: ;
                    endcase
                end
            end
        end
        cs_p = ee_cs;
        sck_p = ee_sck;
        ee_di = ee_cs ? (rd_act ? rd_bit : (prog_cnt == 0)) : 1'b0;
    end

    // ---------------- helpers ----------------
    logic [15:0] got_r;
    logic        got_e, got_busy, aft_busy, aft_done;
    int          base_sel, base_log;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [5:0] a, input logic [15:0] d);
        int n;
        base_sel = nsel;
        base_log = nlog;
        @(negedge clk);
        op = o; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 6000) begin @(negedge clk); n++; end
        got_r = rdata; got_e = err; got_busy = busy;
        @(negedge clk);
        aft_busy = busy; aft_done = done;
    endtask

    task automatic t_reset();
        chk(ee_cs == 1'b0 && ee_do == 1'b0, "R1 cs/do at reset", {ee_cs, ee_do}, 0);
        chk(ee_sck == 1'b1, "R1 sck at reset", ee_sck, 1);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 flags at reset", {busy, done, err}, 0);
    endtask

    task automatic t_wen();
        run_op(2'd2, 6'h2D, 16'hFFFF);
        chk(nsel - base_sel == 1, "R12 wen single selection", nsel - base_sel, 1);
        chk(log_code[base_log & 63] == 'b10011, "R2 wen code", log_code[base_log & 63], 'b10011);
        chk(log_addr[base_log & 63] == 0, "R12 wen address zero", log_addr[base_log & 63], 0);
        chk(wen == 1'b1, "R12 device write enabled", wen, 1);
        chk(got_busy == 1'b1, "R11 busy with done", got_busy, 1);
        chk(aft_busy == 1'b0 && aft_done == 1'b0, "R11 done one cycle", {aft_busy, aft_done}, 0);
    endtask

    task automatic t_wds();
        run_op(2'd3, 6'h3F, 16'h0);
        chk(log_code[base_log & 63] == 'b10000, "R2 wds code", log_code[base_log & 63], 'b10000);
        chk(log_addr[base_log & 63] == 0, "R12 wds address zero", log_addr[base_log & 63], 0);
        chk(nlog - base_log == 1, "R12 wds frame only", nlog - base_log, 1);
        chk(wen == 1'b0, "R12 device write disabled", wen, 0);
    endtask

    task automatic t_write(input logic [5:0] a, input logic [15:0] d);
        run_op(2'd1, a, d);
        chk(nsel - base_sel == 4, "R7 four selections", nsel - base_sel, 4);
        chk(log_code[base_log & 63] == 'b10011, "R7 first is wen", log_code[base_log & 63], 'b10011);
        chk(log_code[(base_log + 1) & 63] == 'b10101, "R2 write code", log_code[(base_log + 1) & 63], 'b10101);
        chk(log_addr[(base_log + 1) & 63] == int'(a), "R2 write address", log_addr[(base_log + 1) & 63], int'(a));
        chk(log_code[(base_log + 2) & 63] == 'b10000, "R7 last is wds", log_code[(base_log + 2) & 63], 'b10000);
        chk(mem[a] == d, "R7 word stored", mem[a], d);
        chk(got_e == 1'b0, "R8 no error on ready", got_e, 0);
        chk(sel_len[(base_sel + 2) & 63] == 3 * H + 3 * P, "R8 poll ends on third check",
            sel_len[(base_sel + 2) & 63], 3 * H + 3 * P);
    endtask

    task automatic t_read(input logic [5:0] a, input logic [15:0] d);
        run_op(2'd0, a, d ^ 16'hFFFF);
        chk(got_r == d, "R6 read word", got_r, d);
        chk(log_code[base_log & 63] == 'b10110 && log_addr[base_log & 63] == int'(a), "R2 read frame",
            log_code[base_log & 63], 'b10110);
        chk(period == 2 * H, "R3 bit cell length", period, 2 * H);
        chk(got_e == 1'b0, "R9 err cleared on next start", got_e, 0);
    endtask

    task automatic t_timeout();
        prog_delay = 1000;
        run_op(2'd1, 6'h01, 16'h1111);
        chk(got_e == 1'b1, "R9 timeout sets err", got_e, 1);
        chk(sel_len[(base_sel + 2) & 63] == 3 * H + M * P, "R9 poll length at timeout",
            sel_len[(base_sel + 2) & 63], 3 * H + M * P);
        chk(log_code[(base_log + 2) & 63] == 'b10000, "R9 wds after timeout", log_code[(base_log + 2) & 63], 'b10000);
        prog_delay = 60;
        repeat (1100) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        int s0, l0;
        int n;
        s0 = nsel; l0 = nlog;
        @(negedge clk);
        op = 2'd2; addr = 6'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        op = 2'd0; addr = 6'h03; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 6000) begin @(negedge clk); n++; end
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R10 idle after ignored start", busy, 0);
        chk(nsel - s0 == 1, "R10 start while busy ignored", nsel - s0, 1);
        chk(log_code[l0 & 63] == 'b10011 && nlog - l0 == 1, "R10 only first op ran", log_code[l0 & 63], 'b10011);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_wen();
        t_wds();
        t_write(6'h2A, 16'hA5C3);
        repeat (100) @(negedge clk);
        t_read(6'h2A, 16'hA5C3);
        t_write(6'h15, 16'h8001);
        repeat (100) @(negedge clk);
        t_read(6'h15, 16'h8001);
        t_timeout();
        t_read(6'h15, 16'h8001);
        t_busy_ignore();
        chk(viol_sel == 0, "R4 select/deselect pin order", viol_sel, 0);
        chk(viol_desel == 0, "R5 data-out low at deselect", viol_desel, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule